// File: doc/BRIEF.md
# Shift-Add Symmetric FIR Filter

This block is a seven-tap FIR filter whose coefficients are fixed in hardware: 17, -90, 241, 902, 241, -90, 17. It contains no multiplier. Every product is formed from shifted copies of the stored samples, and each coefficient is recoded into a short signed-digit form. Because the impulse response is symmetric, each pair of samples that share a coefficient is summed once, before the shifts are applied.

All shifted terms, together with one constant row that completes the two's complement negations, go into a carry-save tree built from 4:2 compressors. One carry-propagate adder at the end forms the full-precision result. Samples enter on a valid strobe, and the delay line moves only on accepted samples. Each accepted sample produces one output word, marked by an output-valid pulse, a fixed number of cycles later.

The reset is asynchronous and active low. Its deassertion is expected to be synchronous to `clk`.

Top module: `fir_sa_top`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first output, `out_valid` is 0 and `dout` is 0. Reset clears the whole sample history to zero, so the outputs that follow a reset treat every older sample as 0.
- R2: For the n-th accepted sample, `dout` equals 17·x[n] − 90·x[n−1] + 241·x[n−2] + 902·x[n−3] + 241·x[n−4] − 90·x[n−5] + 17·x[n−6]. Here x[k] is the k-th accepted `din` read as 8-bit two's complement, and `dout` is read as 19-bit two's complement.
- R3: When `in_valid` is low, `din` is ignored and the sample history does not change. Idle cycles between accepted samples, whatever `din` carries during them, leave later outputs unchanged.
- R4: Each rising clock edge with `in_valid` high produces exactly one `out_valid` pulse, 3 rising edges later. `out_valid` is never high at any other time.
- R5: `dout` changes only on edges where `out_valid` becomes or stays high. Otherwise it holds its last value.
- R6: The result is exact over the full input range. Outputs lie between −204364 and +203126, including runs of −128 and +127 and the sign patterns that reach both bounds.
- R7: A single sample of 1, followed by six samples of 0, produces the outputs 17, −90, 241, 902, 241, −90, 17 in that order.
- R8: `in_valid` may stay high on every cycle. One sample is accepted and one result delivered per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `din` on this edge and advance the delay line |
| din | input | 8 | Sample, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new `dout` |
| dout | output | 19 | Filter result, two's complement, full precision |

## Verification
Each result is due 3 rising edges after the edge that accepted its sample. The bench drives inputs on falling edges and records the cycle count with each expected value it queues. The monitor samples on falling edges and checks that every `out_valid` pulse arrives exactly 3 counted edges after its entry was queued. On every cycle without a pulse, it checks that `dout` still holds its last value. The reset checks are taken two cycles into reset, and the outputs that follow a reset are compared with a history of zeros.

// File: rtl/fir_sa_pkg.sv
package fir_sa_pkg;
  // default sample width
  localparam int SAMPLE_W = 8;
  // taps in the impulse response
  localparam int NUM_TAPS = 7;
  // growth bits: sum of |coefficients| = 1598 < 2**11
  localparam int GAIN_W   = 11;
  // shifted terms plus one constant row
  localparam int NUM_ROWS = 14;
  // terms that are inverted and need a +1 each
  localparam int NEG_ROWS = 7;
  // sums of the positive and of the negative coefficient magnitudes
  localparam int POS_SUM  = 1418;
  localparam int NEG_SUM  = 180;
endpackage

// File: rtl/fir_sa_tapline.sv
module fir_sa_tapline #(
  parameter int DATA_W = 8,
  parameter int NTAPS  = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             din,
  output logic [NTAPS-1:0][DATA_W-1:0]  taps
);

  logic [NTAPS-1:0][DATA_W-1:0] taps_d;

  // next state: newest sample in slot 0, older samples move up one slot
  always_comb begin
    taps_d[0] = din;
    for (int i = 1; i < NTAPS; i++) begin
      taps_d[i] = taps[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (in_valid) begin
      taps <= taps_d;
    end
  end

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(taps)); // R3

  AST_TAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taps[0] == $past(din))); // R2

endmodule

// File: rtl/fir_sa_ppgen.sv
module fir_sa_ppgen
  import fir_sa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] taps,
  output logic [NUM_ROWS-1:0][ACC_W-1:0]  rows
);

  localparam int PW = DATA_W + 1;

  logic [PW-1:0]    pair [3];
  logic [ACC_W-1:0] e_out, e_mid, e_in, e_ctr;

  // symmetric pre-adders: taps j and NUM_TAPS-1-j share one coefficient
  for (genvar g = 0; g < 3; g++) begin : g_pre
    assign pair[g] = {taps[g][DATA_W-1], taps[g]}
                   + {taps[NUM_TAPS-1-g][DATA_W-1], taps[NUM_TAPS-1-g]};
  end

  function automatic logic [ACC_W-1:0] sext_pair(input logic [PW-1:0] v);
    return {{(ACC_W-PW){v[PW-1]}}, v};
  endfunction

  always_comb begin
    e_out = sext_pair(pair[0]);
    e_mid = sext_pair(pair[1]);
    e_in  = sext_pair(pair[2]);
    e_ctr = {{(ACC_W-DATA_W){taps[3][DATA_W-1]}}, taps[3]};
    // 17 = 16 + 1
    rows[0]  = e_out << 4;
    rows[1]  = e_out;
    // -90 = -64 - 16 - 8 - 2 (inverted; the +1 goes in the constant row)
    rows[2]  = ~(e_mid << 6);
    rows[3]  = ~(e_mid << 4);
    rows[4]  = ~(e_mid << 3);
    rows[5]  = ~(e_mid << 1);
    // 241 = 256 - 16 + 1
    rows[6]  = e_in << 8;
    rows[7]  = ~(e_in << 4);
    rows[8]  = e_in;
    // 902 = 1024 - 128 + 8 - 2
    rows[9]  = e_ctr << 10;
    rows[10] = ~(e_ctr << 7);
    rows[11] = e_ctr << 3;
    rows[12] = ~(e_ctr << 1);
    // completes the two's complement of every inverted row
    rows[13] = ACC_W'(NEG_ROWS);
  end

endmodule

// File: rtl/fir_sa_comp42.sv
module fir_sa_comp42 #(
  parameter int W = 19
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  // two full adders per column; the lateral carry depends only on a, b, c,
  // so nothing ripples across the word
  always_comb begin : p_cols
    logic lat_in;
    logic lat_out;
    logic s_fa;
    lat_in  = 1'b0;
    sum_o   = '0;
    carry_o = '0;
    for (int i = 0; i < W; i++) begin
      s_fa     = a[i] ^ b[i] ^ c[i];
      lat_out  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
      sum_o[i] = s_fa ^ d[i] ^ lat_in;
      if (i < W-1) begin
        carry_o[i+1] = (s_fa & d[i]) | (s_fa & lat_in) | (d[i] & lat_in);
      end
      lat_in = lat_out;
    end
  end

endmodule

// File: rtl/fir_sa_csa_tree.sv
module fir_sa_csa_tree
  import fir_sa_pkg::*;
#(
  parameter int W = 19
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]               sum_o,
  output logic [W-1:0]               carry_o
);

  localparam int L1_CMP  = NUM_ROWS / 4;
  localparam int L1_ROWS = 2 * L1_CMP + (NUM_ROWS - 4 * L1_CMP);

  logic [W-1:0] lvl1 [L1_ROWS];
  logic [W-1:0] lvl2 [4];
  logic [W-1:0] rows_total;

  // level 1: 14 rows to 8
  for (genvar g = 0; g < L1_CMP; g++) begin : g_l1
    fir_sa_comp42 #(.W(W)) u_cmp (
      .a(rows[4*g]), .b(rows[4*g+1]), .c(rows[4*g+2]), .d(rows[4*g+3]),
      .sum_o(lvl1[2*g]), .carry_o(lvl1[2*g+1])
    );
  end
  for (genvar g = 4 * L1_CMP; g < NUM_ROWS; g++) begin : g_l1_pass
    assign lvl1[2*L1_CMP + g - 4*L1_CMP] = rows[g];
  end

  // level 2: 8 rows to 4
  for (genvar g = 0; g < 2; g++) begin : g_l2
    fir_sa_comp42 #(.W(W)) u_cmp (
      .a(lvl1[4*g]), .b(lvl1[4*g+1]), .c(lvl1[4*g+2]), .d(lvl1[4*g+3]),
      .sum_o(lvl2[2*g]), .carry_o(lvl2[2*g+1])
    );
  end

  // level 3: 4 rows to 2
  fir_sa_comp42 #(.W(W)) u_l3 (
    .a(lvl2[0]), .b(lvl2[1]), .c(lvl2[2]), .d(lvl2[3]),
    .sum_o(sum_o), .carry_o(carry_o)
  );

  // plain row sum, only used to check the tree
  always_comb begin
    rows_total = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      rows_total = rows_total + rows[i];
    end
  end

  AST_TREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_o + carry_o) == rows_total); // R2

endmodule

// File: rtl/fir_sa_top.sv
module fir_sa_top
  import fir_sa_pkg::*;
#(
  parameter  int DATA_W = SAMPLE_W,
  localparam int ACC_W  = DATA_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] din,
  output logic              out_valid,
  output logic [ACC_W-1:0]  dout
);

  localparam longint OUT_MAX = (longint'(2) ** (DATA_W-1) - 1) * POS_SUM
                             + (longint'(2) ** (DATA_W-1)) * NEG_SUM;
  localparam longint OUT_MIN = -((longint'(2) ** (DATA_W-1)) * POS_SUM
                             + (longint'(2) ** (DATA_W-1) - 1) * NEG_SUM);

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
  logic [NUM_ROWS-1:0][ACC_W-1:0]  rows;
  logic [ACC_W-1:0]                tree_sum, tree_carry;
  logic [ACC_W-1:0]                sum_q, carry_q;
  logic [ACC_W-1:0]                dout_d;
  logic                            vld1, vld2;

  fir_sa_tapline #(.DATA_W(DATA_W), .NTAPS(NUM_TAPS)) u_taps (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din), .taps(taps)
  );

  fir_sa_ppgen #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pp (
    .taps(taps), .rows(rows)
  );

  fir_sa_csa_tree #(.W(ACC_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .rows(rows),
    .sum_o(tree_sum), .carry_o(tree_carry)
  );

  // final carry-propagate add
  always_comb begin
    dout_d = sum_q + carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1      <= 1'b0;
      vld2      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      vld1      <= in_valid;
      vld2      <= vld1;
      out_valid <= vld2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (vld1) begin
      sum_q   <= tree_sum;
      carry_q <= tree_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (vld2) begin
      dout <= dout_d;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld2 |=> $stable(dout)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(dout)) <= OUT_MAX &&
                   longint'($signed(dout)) >= OUT_MIN)); // R6

endmodule

// File: tb/fir_sa_top_bench.sv
`timescale 1ns/1ps
module fir_sa_top_bench;

  localparam int DW = 8;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] din;
  logic          out_valid;
  logic [AW-1:0] dout;

  fir_sa_top u_fir_sa_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din),
    .out_valid(out_valid), .dout(dout)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];

  int hist[7];
  const int COEF[7] = '{17, -90, 241, 902, 241, -90, 17};

  bit            have_last = 1'b0;
  logic [AW-1:0] last_dout;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_y();
    int acc = 0;
    for (int k = 0; k < 7; k++) acc += COEF[k] * hist[k];
    return acc;
  endfunction

  task automatic send(input int x, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    din      = x[DW-1:0];
    for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    exp_q.push_back(ref_y());
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (junk) din = DW'($urandom);
    end
  endtask

  task automatic reset_mid();
    idle(1, 1'b0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(dout == '0, "R1 dout in reset", int'($signed(dout)), 0);
    for (int k = 0; k < 7; k++) hist[k] = 0;
    rst_n     = 1'b1;
    last_dout = '0;
    have_last = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (out_valid) begin
        int sd;
        sd = int'($signed(dout));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected out_valid", sd, 0);
        end else begin
          int    e;
          int    c;
          string t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          check(sd == e, t, sd, e);
          check((cyc - c) == 3, "R4 latency", cyc - c, 3);
        end
        last_dout = dout;
        have_last = 1'b1;
      end else if (have_last) begin
        check(dout === last_dout, "R5 hold", int'($signed(dout)), int'($signed(last_dout)));
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    din      = '0;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(dout == '0, "R1 dout after reset", int'($signed(dout)), 0);
    rst_n     = 1'b1;
    last_dout = '0;
    have_last = 1'b1;
    idle(3, 1'b1);

    // R7 impulse, back to back
    send(1, "R7 impulse");
    for (int i = 0; i < 6; i++) send(0, "R7 impulse");
    idle(5, 1'b0);

    // R3 impulse with idle gaps carrying junk
    send(1, "R3 gapped impulse");
    idle(3, 1'b1);
    for (int i = 0; i < 6; i++) begin
      send(0, "R3 gapped impulse");
      idle(2, 1'b1);
    end
    idle(3, 1'b1);

    // R6 extremes
    for (int i = 0; i < 9; i++) send(127, "R6 all +127");
    for (int i = 0; i < 9; i++) send(-128, "R6 all -128");
    for (int k = 6; k >= 0; k--) send((COEF[k] > 0) ? 127 : -128, "R6 max pattern");
    for (int k = 6; k >= 0; k--) send((COEF[k] > 0) ? -128 : 127, "R6 min pattern");
    for (int i = 0; i < 10; i++) send((i % 2 == 0) ? -128 : 127, "R6 alternating");
    idle(4, 1'b0);

    // R8 full-rate random stream
    for (int i = 0; i < 150; i++) send($signed(DW'($urandom)), "R8 back-to-back");
    idle(4, 1'b0);

    // R2 random samples with random gaps
    for (int i = 0; i < 120; i++) begin
      send($signed(DW'($urandom)), "R2 random gapped");
      idle($urandom_range(0, 3), 1'b1);
    end
    idle(4, 1'b0);

    // R1 reset clears history mid-run
    for (int i = 0; i < 5; i++) send($signed(DW'($urandom)), "R2 pre-reset");
    reset_mid();
    send(-128, "R1 post-reset history");
    for (int i = 0; i < 6; i++) send(0, "R1 post-reset history");
    for (int i = 0; i < 4; i++) send(127, "R1 post-reset history");

    idle(8, 1'b0);
    check(exp_q.size() == 0, "R4 missing outputs", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule